// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches page translations for one processor. Every slot stores a virtual page number, a 4-bit address-space tag and a page-table word made of a valid flag, a referenced flag, a modified flag, a 2-bit protection code and a 20-bit frame number. A lookup offers a page number and the current address-space tag. The block compares them against all slots at once and answers in the same cycle with a hit flag and the stored fields. A hit updates the referenced and modified state of the slot in the following clock edge.

Translations are installed through a fill port. The fill port first reuses a slot that already holds the same page and tag. If there is none, it takes the lowest-numbered empty slot. Only when every slot is occupied does it evict the least recently used slot. Because slots carry an address-space tag, a context switch can leave the table intact. Software still has two ways to remove entries: it can drop every entry at once, or it can drop only the entries of one tag.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is empty. Every lookup misses, and on a miss `lk_pfn`, `lk_prot`, `lk_valid`, `lk_ref`, `lk_mod` and `lk_fault` are all 0.
- R2: A lookup hits only when a valid slot holds both the same page number and the same address-space tag. It then returns that slot's frame number and protection code in the same cycle. The same page under another tag misses.
- R3: A fill stores the entry with valid=1, referenced=0 and modified=`fill_mod`. If a valid slot already holds the same page and tag, that slot is overwritten, so at most one slot ever matches a key.
- R4: When no slot matches, a fill goes to the lowest-numbered empty slot and evicts no valid entry.
- R5: When the table is full and no slot matches, a fill replaces the least recently used slot. Both fills and committed hits count as uses.
- R6: The referenced output shows the stored value before the access. A committed hit sets the referenced bit, so the next lookup of that slot reports `lk_ref`=1.
- R7: A write lookup (`lk_write`=1) that hits a slot with protection bit 1 set is permitted, and it sets that slot's modified bit.
- R8: A write lookup that hits a slot with protection bit 1 clear is read-only. It raises `lk_fault` in the same cycle and changes nothing: the referenced bit, the modified bit and the recency order all stay as they were.
- R9: `flush_all` empties every slot from the next cycle on.
- R10: `flush_asid_en` empties exactly the slots whose tag equals `flush_asid` and leaves all other slots as they were.
- R11: Operations in the same cycle are applied in this priority order: `flush_all`, then `flush_asid_en`, then fill, then the lookup update. A lower-priority operation in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a store access |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_fault | output | 1 | Store to read-only page |
| lk_pfn | output | 20 | Frame number of matched slot |
| lk_prot | output | 2 | Protection code, bit 1 = writable |
| lk_valid | output | 1 | Valid flag of matched slot |
| lk_ref | output | 1 | Referenced flag before this access |
| lk_mod | output | 1 | Modified flag before this access |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Tag to install |
| fill_prot | input | 2 | Protection code to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_mod | input | 1 | Initial modified flag |
| flush_all | input | 1 | Empty every slot |
| flush_asid_en | input | 1 | Empty slots of one tag |
| flush_asid | input | ASID_W | Tag to flush |

## Verification
A corrupted recency order does not show up on any port right away. It appears only at the next eviction from a full table, when the wrong translation disappears and a later lookup misses. For this reason, the eviction checks first set up a known use order and then probe both the survivors and the expected victim. If two slots hold the same key, or a per-tag flush misses a slot, the next lookup with that key shows the error. A referenced or modified bit that is not written back shows up exactly one cycle later, on the next lookup of the same slot.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PFN_W  = 20;
  localparam int PROT_W = 2;

  typedef struct packed {
    logic              v;
    logic              r;
    logic              m;
    logic [PROT_W-1:0] prot;
    logic [PFN_W-1:0]  pfn;
  } pte_t;

  // Protection bit 1 grants store permission.
  function automatic logic prot_writable(input logic [PROT_W-1:0] p);
    return p[1];
  endfunction

  function automatic logic store_faults(input logic is_write, input logic [PROT_W-1:0] p);
    return is_write & ~prot_writable(p);
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [VPN_W-1:0]          key_vpn,
  input  logic [ASID_W-1:0]         key_asid,
  input  logic [N-1:0][VPN_W-1:0]   tag_vpn,
  input  logic [N-1:0][ASID_W-1:0]  tag_asid,
  input  logic [N-1:0]              valid,
  output logic [N-1:0]              hit_vec,
  output logic                      hit_any,
  output logic [IDX_W-1:0]          hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tag_vpn[g] == key_vpn) && (tag_asid[g] == key_asid);
  end

  assign hit_any = |hit_vec;

  // Matches are unique, so OR-combining the indices yields the hit slot.
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  // Each slot holds a distinct age rank; rank 0 is newest, N-1 oldest.
  logic [N-1:0][IDX_W-1:0] age;
  logic [N-1:0]            oldest_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)          age[i] <= '0;
        else if (age[i] < age[touch_idx])    age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      oldest_flag[i] = (age[i] == IDX_W'(N - 1));
      if (oldest_flag[i]) victim_idx = IDX_W'(i);
    end
  end

  a_r5_touch_is_newest: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age[$past(touch_idx)] == '0);
  a_r5_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_flag));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid,
  input  logic             match_any,
  input  logic [IDX_W-1:0] match_idx,
  input  logic [IDX_W-1:0] lru_idx,
  output logic [IDX_W-1:0] slot
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    if (match_any)     slot = match_idx;
    else if (free_any) slot = free_idx;
    else               slot = lru_idx;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_en,
  input  logic                      lk_write,
  input  logic [VPN_W-1:0]          lk_vpn,
  input  logic [ASID_W-1:0]         lk_asid,
  output logic                      lk_hit,
  output logic                      lk_fault,
  output logic [tlb_pkg::PFN_W-1:0] lk_pfn,
  output logic [tlb_pkg::PROT_W-1:0] lk_prot,
  output logic                      lk_valid,
  output logic                      lk_ref,
  output logic                      lk_mod,
  input  logic                      fill_en,
  input  logic [VPN_W-1:0]          fill_vpn,
  input  logic [ASID_W-1:0]         fill_asid,
  input  logic [tlb_pkg::PROT_W-1:0] fill_prot,
  input  logic [tlb_pkg::PFN_W-1:0] fill_pfn,
  input  logic                      fill_mod,
  input  logic                      flush_all,
  input  logic                      flush_asid_en,
  input  logic [ASID_W-1:0]         flush_asid
);
  import tlb_pkg::*;

  logic [N-1:0][VPN_W-1:0]  tag_vpn;
  logic [N-1:0][ASID_W-1:0] tag_asid;
  pte_t [N-1:0]             ent;
  logic [N-1:0]             valid_vec;

  always_comb begin
    for (int i = 0; i < N; i++) valid_vec[i] = ent[i].v;
  end

  // Lookup and fill comparators
  logic [N-1:0]     lk_vec, fill_vec;
  logic             lk_any, fill_any;
  logic [IDX_W-1:0] lk_idx, fill_idx, lru_idx, fill_slot;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .key_vpn(lk_vpn), .key_asid(lk_asid), .tag_vpn(tag_vpn), .tag_asid(tag_asid),
    .valid(valid_vec), .hit_vec(lk_vec), .hit_any(lk_any), .hit_idx(lk_idx));

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .key_vpn(fill_vpn), .key_asid(fill_asid), .tag_vpn(tag_vpn), .tag_asid(tag_asid),
    .valid(valid_vec), .hit_vec(fill_vec), .hit_any(fill_any), .hit_idx(fill_idx));

  tlb_victim #(.N(N)) u_victim (
    .valid(valid_vec), .match_any(fill_any), .match_idx(fill_idx),
    .lru_idx(lru_idx), .slot(fill_slot));

  // Named internal events
  pte_t sel;
  logic flush_any, fill_commit, lk_commit, touch_en;
  logic [IDX_W-1:0] touch_idx;

  assign sel         = ent[lk_idx];
  assign lk_hit      = lk_en & lk_any;
  assign lk_fault    = lk_hit & store_faults(lk_write, sel.prot);
  assign lk_pfn      = lk_hit ? sel.pfn  : '0;
  assign lk_prot     = lk_hit ? sel.prot : '0;
  assign lk_valid    = lk_hit & sel.v;
  assign lk_ref      = lk_hit & sel.r;
  assign lk_mod      = lk_hit & sel.m;

  assign flush_any   = flush_all | flush_asid_en;
  assign fill_commit = fill_en & ~flush_any;
  assign lk_commit   = lk_hit & ~lk_fault & ~fill_en & ~flush_any;
  assign touch_en    = fill_commit | lk_commit;
  assign touch_idx   = fill_commit ? fill_slot : lk_idx;

  tlb_lru #(.N(N)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .victim_idx(lru_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent      <= '0;
      tag_vpn  <= '0;
      tag_asid <= '0;
    end else if (flush_all) begin
      for (int i = 0; i < N; i++) ent[i].v <= 1'b0;
    end else if (flush_asid_en) begin
      for (int i = 0; i < N; i++) begin
        if (tag_asid[i] == flush_asid) ent[i].v <= 1'b0;
      end
    end else if (fill_en) begin
      tag_vpn[fill_slot]  <= fill_vpn;
      tag_asid[fill_slot] <= fill_asid;
      ent[fill_slot]      <= '{v: 1'b1, r: 1'b0, m: fill_mod, prot: fill_prot, pfn: fill_pfn};
    end else if (lk_commit) begin
      ent[lk_idx].r <= 1'b1;
      if (lk_write) ent[lk_idx].m <= 1'b1;
    end
  end

  a_r3_unique_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));
  a_r3_unique_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_vec));
  a_r8_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);
  a_r8_fault_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault && !fill_en && !flush_any) |=> $stable(ent));
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));
  a_r3_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fill_commit |=> valid_vec[$past(fill_slot)]);
  a_r6_hit_marks_ref: assert property (@(posedge clk) disable iff (!rst_n)
    lk_commit |=> ent[$past(lk_idx)].r);
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_en = 0, lk_write = 0;
  logic [19:0] lk_vpn = '0;
  logic [3:0]  lk_asid = '0;
  logic lk_hit, lk_fault, lk_valid, lk_ref, lk_mod;
  logic [19:0] lk_pfn;
  logic [1:0]  lk_prot;
  logic fill_en = 0, fill_mod = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [3:0]  fill_asid = '0;
  logic [1:0]  fill_prot = '0;
  logic flush_all = 0, flush_asid_en = 0;
  logic [3:0] flush_asid = '0;

  int n_run = 0, n_fail = 0;
  logic r_hit, r_fault, r_valid, r_ref, r_mod;
  logic [19:0] r_pfn;
  logic [1:0]  r_prot;

  always #4 clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_write(lk_write), .lk_vpn(lk_vpn),
    .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pfn(lk_pfn),
    .lk_prot(lk_prot), .lk_valid(lk_valid), .lk_ref(lk_ref), .lk_mod(lk_mod),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_prot(fill_prot),
    .fill_pfn(fill_pfn), .fill_mod(fill_mod), .flush_all(flush_all),
    .flush_asid_en(flush_asid_en), .flush_asid(flush_asid));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [3:0] asid, input logic wr);
    @(negedge clk);
    lk_en = 1; lk_vpn = vpn; lk_asid = asid; lk_write = wr;
    #1;
    r_hit = lk_hit; r_fault = lk_fault; r_pfn = lk_pfn; r_prot = lk_prot;
    r_valid = lk_valid; r_ref = lk_ref; r_mod = lk_mod;
    @(posedge clk); #1;
    lk_en = 0; lk_write = 0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [3:0] asid,
                      input logic [1:0] prot, input logic [19:0] pfn, input logic md);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_asid = asid; fill_prot = prot; fill_pfn = pfn; fill_mod = md;
    @(posedge clk); #1;
    fill_en = 0;
  endtask

  task automatic t_reset();
    lookup(20'h5, 4'h1, 1'b0);
    check("R1 hit", r_hit, 0);
    check("R1 pfn", r_pfn, 0);
    check("R1 flags", {r_valid, r_ref, r_mod, r_fault, r_prot}, 0);
  endtask

  task automatic t_basic();
    fill(20'h12345, 4'h3, 2'b10, 20'hABCDE, 1'b0);
    lookup(20'h12345, 4'h3, 1'b0);
    check("R2 hit", r_hit, 1);
    check("R2 pfn", r_pfn, 20'hABCDE);
    check("R2 prot", r_prot, 2'b10);
    check("R3 valid", r_valid, 1);
    check("R6 ref before", r_ref, 0);
    lookup(20'h12345, 4'h4, 1'b0);
    check("R2 other tag", r_hit, 0);
    lookup(20'h12346, 4'h3, 1'b0);
    check("R2 other page", r_hit, 0);
    lookup(20'h12345, 4'h3, 1'b0);
    check("R6 ref after", r_ref, 1);
  endtask

  task automatic t_write();
    lookup(20'h12345, 4'h3, 1'b1);
    check("R7 hit", r_hit, 1);
    check("R7 no fault", r_fault, 0);
    check("R7 mod before", r_mod, 0);
    lookup(20'h12345, 4'h3, 1'b0);
    check("R7 mod after", r_mod, 1);
  endtask

  task automatic t_readonly();
    fill(20'h02222, 4'h3, 2'b01, 20'h11111, 1'b0);
    lookup(20'h02222, 4'h3, 1'b1);
    check("R8 fault", r_fault, 1);
    check("R8 hit", r_hit, 1);
    lookup(20'h02222, 4'h3, 1'b0);
    check("R8 ref kept", r_ref, 0);
    check("R8 mod kept", r_mod, 0);
    check("R8 read ok", r_fault, 0);
  endtask

  task automatic t_inplace();
    fill(20'h12345, 4'h3, 2'b11, 20'h55555, 1'b0);
    lookup(20'h12345, 4'h3, 1'b0);
    check("R3 new pfn", r_pfn, 20'h55555);
    check("R3 ref cleared", r_ref, 0);
    check("R3 mod from fill", r_mod, 0);
  endtask

  task automatic t_flush_all();
    @(negedge clk); flush_all = 1; @(posedge clk); #1; flush_all = 0;
    lookup(20'h12345, 4'h3, 1'b0);
    check("R9 gone a", r_hit, 0);
    lookup(20'h02222, 4'h3, 1'b0);
    check("R9 gone b", r_hit, 0);
  endtask

  task automatic t_lru();
    int hits = 0;
    for (int i = 0; i < 16; i++) fill(20'(i), 4'h1, 2'b10, 20'(i + 'h100), 1'b1);
    for (int i = 0; i < 16; i++) begin
      lookup(20'(i), 4'h1, 1'b0);
      hits += int'(r_hit && r_pfn == 20'(i + 'h100));
    end
    check("R4 all sixteen held", hits, 16);
    lookup(20'h0, 4'h1, 1'b0);
    fill(20'h100, 4'h1, 2'b10, 20'hFFFFF, 1'b0);
    lookup(20'h1, 4'h1, 1'b0);
    check("R5 oldest evicted", r_hit, 0);
    lookup(20'h0, 4'h1, 1'b0);
    check("R5 recent kept", r_hit, 1);
    lookup(20'h100, 4'h1, 1'b0);
    check("R5 new present", r_pfn, 20'hFFFFF);
    check("R3 fill_mod clear", r_mod, 0);
  endtask

  task automatic t_asid_flush();
    int hits = 0;
    fill(20'h200, 4'h2, 2'b10, 20'h22222, 1'b0);
    @(negedge clk); flush_asid_en = 1; flush_asid = 4'h2; @(posedge clk); #1; flush_asid_en = 0;
    lookup(20'h200, 4'h2, 1'b0);
    check("R10 tag flushed", r_hit, 0);
    lookup(20'h3, 4'h1, 1'b0);
    check("R10 other tag kept", r_hit, 1);
    fill(20'h300, 4'h5, 2'b10, 20'h33333, 1'b0);
    for (int i = 3; i < 16; i++) begin
      lookup(20'(i), 4'h1, 1'b0);
      hits += int'(r_hit);
    end
    lookup(20'h0, 4'h1, 1'b0);   hits += int'(r_hit);
    lookup(20'h100, 4'h1, 1'b0); hits += int'(r_hit);
    check("R4 no eviction into free slot", hits, 15);
    lookup(20'h300, 4'h5, 1'b0);
    check("R4 fill present", r_hit, 1);
  endtask

  task automatic t_priority();
    @(negedge clk);
    flush_all = 1; fill_en = 1; fill_vpn = 20'h777; fill_asid = 4'h7;
    fill_prot = 2'b10; fill_pfn = 20'h77777; fill_mod = 0;
    @(posedge clk); #1; flush_all = 0; fill_en = 0;
    lookup(20'h777, 4'h7, 1'b0);
    check("R11 fill lost to flush", r_hit, 0);
    lookup(20'h3, 4'h1, 1'b0);
    check("R11 flush applied", r_hit, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_write();
    t_readonly();
    t_inplace();
    t_flush_all();
    t_lru();
    t_asid_flush();
    t_priority();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule